// File: doc/BRIEF.md
# Composite Peripheral Clock Generator

This block derives one peripheral clock from four reference sources. Each reference reaches the block as a one-cycle edge strobe in the core clock domain, one strobe per reference edge. A source selector picks the reference, a divider counts its edges, and a gate can hold the result low. The output level toggles once every `ratio` edges of the chosen reference, so its frequency is the reference frequency divided by the ratio.

The ratio comes from plain register fields through a build-time decoder. The default decoder multiplies two cascaded divide fields. Three alternative decoders use only the first field: a six-entry table, a single-bit divide by 1 or 2, and a single-bit divide by 2 or 4. Software reads back the ratio in effect and a nominal output rate. That rate is the selected reference's nominal rate divided by the ratio and rounded up. Every nominal rate is a build parameter.

The block does not switch its output in the middle of a period. A new source selection or gate setting is taken only in a cycle where the output is low. A new ratio is loaded only at a divider terminal count, or while the gate holds the output off. There is no streaming data path, so every pin is a plain control or status pin.

Top module: `periph_clk_composite`

## Requirements
- R1: `src_sel` picks which bit of `ref_tick` drives the divider. Code k selects `ref_tick[k]`.
- R2: With `DIV_MODE` = cascade, the ratio is the product of `div_a` and `div_b`, and a field value of 0 counts as 1. For example, 7 and 7 give 49, and 0 and 0 give 1.
- R3: With `DIV_MODE` = six-entry table, codes 1 to 6 of `div_a` give ratios 1 to 6. Code 0 gives 1, code 7 gives 6, and `div_b` is ignored.
- R4: With `DIV_MODE` = single-bit low, `div_a[0]` = 0 gives ratio 1 and `div_a[0]` = 1 gives ratio 2.
- R5: With `DIV_MODE` = single-bit high, `div_a[0]` = 0 gives ratio 2 and `div_a[0]` = 1 gives ratio 4.
- R6: While the gate is open, `clk_out` changes one cycle after every `ratio`-th strobe of the active reference, and at no other time.
- R7: While the gate setting in effect is 1, `clk_out` is 0. Once it clears, toggling resumes.
- R8: The block adopts a new `src_sel` or `gate_off` only in a cycle where `clk_out` is 0. A change made while `clk_out` is 1 waits for the output to go low.
- R9: A changed ratio takes effect only at a terminal count or while gated. `ratio_out` always shows the ratio in effect.
- R10: `rate_out` equals the nominal rate of the source in effect divided by `ratio_out`, rounded up.
- R11: After reset, `clk_out` is 0, `ratio_out` is 1, the gate is closed, and `rate_out` is the nominal rate of reference 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | NUM_REF | Edge strobe of each reference |
| src_sel | input | SEL_W | Reference select field |
| div_a | input | FIELD_W | First divide field |
| div_b | input | FIELD_W | Second divide field (cascade mode only) |
| gate_off | input | 1 | 1 holds the output off |
| clk_out | output | 1 | Divided, gated clock level |
| ratio_out | output | RATIO_W | Division ratio in effect |
| rate_out | output | RATE_W | Nominal output rate, rounded up |

## Verification
The bench builds four copies of the block, one for each `DIV_MODE` value. All four take the same field and strobe stimulus, so every decoder sees field codes 0 and 7 and both values of bit 0. Each copy uses `FIELD_W` = 3 and four references: one strobing every cycle, one every second cycle, one every third cycle, and one strobing at random. This covers ratio-1 toggling on every cycle, the largest cascade ratio of 49, and selection changes that arrive while the output is high. The nominal rates are chosen so that most divisions leave a remainder, which exercises the round-up.

// File: rtl/periph_clk_pkg.sv
package periph_clk_pkg;

  typedef enum logic [1:0] {
    DIVM_CASCADE  = 2'd0,
    DIVM_TABLE6   = 2'd1,
    DIVM_BIT_X1X2 = 2'd2,
    DIVM_BIT_X2X4 = 2'd3
  } div_mode_e;

endpackage

// File: rtl/pclk_ratio_decode.sv
module pclk_ratio_decode #(
  parameter periph_clk_pkg::div_mode_e DIV_MODE = periph_clk_pkg::DIVM_CASCADE,
  parameter int FIELD_W = 3,
  parameter int RATIO_W = 6
) (
  input  logic [FIELD_W-1:0] a_i,
  input  logic [FIELD_W-1:0] b_i,
  output logic [RATIO_W-1:0] ratio_o
);
  import periph_clk_pkg::*;

  generate
    if (DIV_MODE == DIVM_CASCADE) begin : g_cascade
      logic [FIELD_W-1:0] fa, fb;
      assign fa = (a_i == '0) ? FIELD_W'(1) : a_i;
      assign fb = (b_i == '0) ? FIELD_W'(1) : b_i;
      assign ratio_o = RATIO_W'(fa) * RATIO_W'(fb);
    end else if (DIV_MODE == DIVM_TABLE6) begin : g_table6
      logic unused_b;
      assign unused_b = ^b_i;
      assign ratio_o = (a_i == '0) ? RATIO_W'(1) :
                       (a_i > FIELD_W'(6)) ? RATIO_W'(6) : RATIO_W'(a_i);
    end else if (DIV_MODE == DIVM_BIT_X1X2) begin : g_x1x2
      logic unused_ab;
      assign unused_ab = ^{a_i[FIELD_W-1:1], b_i};
      assign ratio_o = a_i[0] ? RATIO_W'(2) : RATIO_W'(1);
    end else begin : g_x2x4
      logic unused_ab;
      assign unused_ab = ^{a_i[FIELD_W-1:1], b_i};
      assign ratio_o = a_i[0] ? RATIO_W'(4) : RATIO_W'(2);
    end
  endgenerate

endmodule

// File: rtl/pclk_src_select.sv
module pclk_src_select #(
  parameter int NUM_REF = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REF-1:0] ref_tick_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               off_i,
  input  logic               out_i,
  output logic [SEL_W-1:0]   sel_q_o,
  output logic               off_next_o,
  output logic               edge_o
);

  logic [SEL_W-1:0] sel_q, sel_next;
  logic             off_q;

  // adopt new settings only while the output level is low
  assign sel_next   = out_i ? sel_q : sel_i;
  assign off_next_o = out_i ? off_q : off_i;
  assign edge_o     = ref_tick_i[sel_next];
  assign sel_q_o    = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      off_q <= 1'b1;
    end else begin
      sel_q <= sel_next;
      off_q <= off_next_o;
    end
  end

  // R8
  sel_low_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> !$past(out_i));

  // R8
  gate_low_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != $past(off_q)) |-> !$past(out_i));

  // R7
  gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> !out_i);

endmodule

// File: rtl/pclk_edge_divider.sv
module pclk_edge_divider #(
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               edge_i,
  input  logic               off_i,
  input  logic [RATIO_W-1:0] new_ratio_i,
  output logic               out_o,
  output logic [RATIO_W-1:0] ratio_o
);

  logic [RATIO_W-1:0] cnt_q, ratio_q;
  logic               out_q, term;

  assign term    = (cnt_q == ratio_q - RATIO_W'(1));
  assign out_o   = out_q;
  assign ratio_o = ratio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= RATIO_W'(1);
    end else if (off_i) begin
      out_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= new_ratio_i;
    end else if (edge_i) begin
      if (term) begin
        out_q   <= ~out_q;
        cnt_q   <= '0;
        ratio_q <= new_ratio_i;
      end else begin
        cnt_q <= cnt_q + RATIO_W'(1);
      end
    end
  end

  // R6
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

  // R6
  toggle_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> ($past(edge_i) || $past(off_i)));

  // R9
  ratio_at_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != $past(ratio_q)) |-> ($past(off_i) || ($past(edge_i) && $past(cnt_q) == $past(ratio_q) - RATIO_W'(1))));

endmodule

// File: rtl/pclk_rate_calc.sv
module pclk_rate_calc #(
  parameter int NUM_REF = 4,
  parameter int SEL_W   = 2,
  parameter int RATE_W  = 16,
  parameter int RATIO_W = 6,
  parameter logic [NUM_REF*RATE_W-1:0] REF_RATES = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [RATE_W-1:0]  rate_o
);
  localparam int NW = RATE_W + 1;

  logic [RATE_W-1:0] src;
  logic [NW-1:0]     num, den;

  assign src    = REF_RATES[sel_i*RATE_W +: RATE_W];
  assign den    = NW'(ratio_i);
  assign num    = {1'b0, src} + den - NW'(1);
  assign rate_o = RATE_W'(num / den);

  // R10
  rate_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rate_o) * int'(ratio_i) >= int'(src)) &&
    ((int'(rate_o) - 1) * int'(ratio_i) < int'(src)));

endmodule

// File: rtl/periph_clk_composite.sv
module periph_clk_composite #(
  parameter periph_clk_pkg::div_mode_e DIV_MODE = periph_clk_pkg::DIVM_CASCADE,
  parameter int NUM_REF = 4,
  parameter int FIELD_W = 3,
  parameter int RATE_W  = 16,
  parameter logic [NUM_REF*RATE_W-1:0] REF_RATES = {NUM_REF{RATE_W'(1000)}},
  localparam int SEL_W   = $clog2(NUM_REF),
  localparam int MAX_R   = ((1 << FIELD_W) - 1) * ((1 << FIELD_W) - 1),
  localparam int RATIO_W = $clog2(MAX_R + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REF-1:0] ref_tick,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [FIELD_W-1:0] div_a,
  input  logic [FIELD_W-1:0] div_b,
  input  logic               gate_off,
  output logic               clk_out,
  output logic [RATIO_W-1:0] ratio_out,
  output logic [RATE_W-1:0]  rate_out
);

  logic [RATIO_W-1:0] new_ratio;
  logic [SEL_W-1:0]   sel_act;
  logic               off_next, src_edge;

  pclk_ratio_decode #(.DIV_MODE(DIV_MODE), .FIELD_W(FIELD_W), .RATIO_W(RATIO_W)) u_dec (
    .a_i(div_a), .b_i(div_b), .ratio_o(new_ratio));

  pclk_src_select #(.NUM_REF(NUM_REF), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .sel_i(src_sel),
    .off_i(gate_off), .out_i(clk_out), .sel_q_o(sel_act),
    .off_next_o(off_next), .edge_o(src_edge));

  pclk_edge_divider #(.RATIO_W(RATIO_W)) u_div (
    .clk(clk), .rst_n(rst_n), .edge_i(src_edge), .off_i(off_next),
    .new_ratio_i(new_ratio), .out_o(clk_out), .ratio_o(ratio_out));

  pclk_rate_calc #(.NUM_REF(NUM_REF), .SEL_W(SEL_W), .RATE_W(RATE_W),
                   .RATIO_W(RATIO_W), .REF_RATES(REF_RATES)) u_rate (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_act), .ratio_i(ratio_out),
    .rate_o(rate_out));

  // R2
  ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (new_ratio != '0) && (ratio_out != '0));

endmodule

// File: tb/periph_clk_composite_test.sv
module periph_clk_composite_test;
  import periph_clk_pkg::*;

  localparam logic [63:0] REFS = {16'd999, 16'd250, 16'd1200, 16'd1000};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ref_tick = '0;
  logic [1:0] src_sel = '0;
  logic [2:0] div_a = '0, div_b = '0;
  logic       gate_off = 1'b1;

  logic        co [4];
  logic [5:0]  ro [4];
  logic [15:0] qo [4];

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  int m_out[4], m_cnt[4], m_ratio[4], m_sel[4], m_off[4];
  int ref_rate[4] = '{1000, 1200, 250, 999};

  always #5 clk = ~clk;

  periph_clk_composite #(.DIV_MODE(DIVM_CASCADE), .REF_RATES(REFS)) uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .src_sel(src_sel), .div_a(div_a),
    .div_b(div_b), .gate_off(gate_off), .clk_out(co[0]), .ratio_out(ro[0]), .rate_out(qo[0]));
  periph_clk_composite #(.DIV_MODE(DIVM_TABLE6), .REF_RATES(REFS)) uut_t6 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .src_sel(src_sel), .div_a(div_a),
    .div_b(div_b), .gate_off(gate_off), .clk_out(co[1]), .ratio_out(ro[1]), .rate_out(qo[1]));
  periph_clk_composite #(.DIV_MODE(DIVM_BIT_X1X2), .REF_RATES(REFS)) uut_b12 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .src_sel(src_sel), .div_a(div_a),
    .div_b(div_b), .gate_off(gate_off), .clk_out(co[2]), .ratio_out(ro[2]), .rate_out(qo[2]));
  periph_clk_composite #(.DIV_MODE(DIVM_BIT_X2X4), .REF_RATES(REFS)) uut_b24 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .src_sel(src_sel), .div_a(div_a),
    .div_b(div_b), .gate_off(gate_off), .clk_out(co[3]), .ratio_out(ro[3]), .rate_out(qo[3]));

  function automatic int ratio_of(int mode, int a, int b);
    case (mode)
      0: return (a == 0 ? 1 : a) * (b == 0 ? 1 : b);
      1: return (a == 0) ? 1 : ((a > 6) ? 6 : a);
      2: return (a % 2 == 1) ? 2 : 1;
      default: return (a % 2 == 1) ? 4 : 2;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced at every rising edge
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (!rst_n) begin
        m_out[k] = 0; m_cnt[k] = 0; m_ratio[k] = 1; m_sel[k] = 0; m_off[k] = 1;
      end else begin
        int ns, noff, nr;
        ns   = (m_out[k] == 0) ? int'(src_sel) : m_sel[k];
        noff = (m_out[k] == 0) ? int'(gate_off) : m_off[k];
        nr   = ratio_of(k, int'(div_a), int'(div_b));
        if (noff != 0) begin
          m_out[k] = 0; m_cnt[k] = 0; m_ratio[k] = nr;
        end else if (ref_tick[ns]) begin
          if (m_cnt[k] == m_ratio[k] - 1) begin
            m_out[k] = 1 - m_out[k]; m_cnt[k] = 0; m_ratio[k] = nr;
          end else m_cnt[k]++;
        end
        m_sel[k] = ns; m_off[k] = noff;
      end
    end
  end

  task automatic compare_all();
    string rtag [4] = '{"R2 R9", "R3 R9", "R4 R9", "R5 R9"};
    for (int k = 0; k < 4; k++) begin
      chk("R1 R6 R7 R8 clk_out", int'(co[k]), m_out[k]);
      chk({rtag[k], " ratio_out"}, int'(ro[k]), m_ratio[k]);
      chk("R10 rate_out", int'(qo[k]), (ref_rate[m_sel[k]] + m_ratio[k] - 1) / m_ratio[k]);
    end
  endtask

  task automatic run(int n, int s, int a, int b, int g);
    src_sel = 2'(s); div_a = 3'(a); div_b = 3'(b); gate_off = g[0];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      cyc++;
      ref_tick[0] = 1'b1;
      ref_tick[1] = (cyc % 2 == 0);
      ref_tick[2] = (cyc % 3 == 0);
      ref_tick[3] = 1'($urandom % 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    for (int k = 0; k < 4; k++) begin
      chk("R11 reset clk_out", int'(co[k]), 0);
      chk("R11 reset ratio_out", int'(ro[k]), 1);
      chk("R11 reset rate_out", int'(qo[k]), 1000);
    end
    rst_n = 1'b1;
    run(40, 0, 0, 0, 0);   // zero fields, every-cycle source
    run(300, 1, 7, 7, 0);  // largest cascade ratio, code 7
    run(150, 2, 3, 2, 0);
    run(30, 2, 3, 2, 1);   // gate closed
    run(150, 3, 6, 0, 0);
    run(100, 0, 5, 3, 0);
    run(100, 1, 1, 1, 0);
    for (int p = 0; p < 50; p++)
      run(20 + int'($urandom % 100), int'($urandom % 4), int'($urandom % 8),
          int'($urandom % 8), int'($urandom % 8 == 0));
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule